// File: doc/BRIEF.md
# Warp Reconvergence Mask Stack

This block keeps the program counter and the active-lane mask for a single warp of 32 lanes that share one instruction address. On each conditional branch it receives one predicate bit per lane together with three addresses: the branch target, the sequential successor and the point where both paths meet again. If every active lane votes the same way, the warp simply moves to the chosen address. If the active lanes disagree, the block runs the branch-target path first, with only the voting lanes enabled. It then runs the sequential path with the remaining lanes enabled. Finally it merges them at the meeting address with the original mask.

The fetch side reports every non-branch step through an advance input that carries the next address. When that address matches the meeting point recorded on top of a small pending-path stack, the block either switches to the second path or restores the saved mask. Because splits push onto a stack, branches nested inside a divergent path unwind in last-in, first-out order. A split that arrives while the stack is full raises a sticky error flag and is discarded, so the entries already on the stack are left intact.

Top module: `simt_warp_reconv`

## Requirements
- R1: After a synchronous active-low reset, `cur_pc` equals the `RESET_PC` parameter (default 0x100), `act_mask` is all ones and `ovf_err` is 0.
- R2: A branch whose predicate is 1 on every active lane moves `cur_pc` to `br_taken_pc` at the next clock edge. A branch whose predicate is 0 on every active lane moves it to `br_fall_pc`. In both cases `act_mask` stays unchanged.
- R3: Predicate bits of lanes that are 0 in `act_mask` have no effect. Uniformity is judged on active lanes only, and inactive lanes never enter either path mask.
- R4: A branch whose active lanes disagree sets `cur_pc` to `br_taken_pc` and `act_mask` to (predicate AND previous mask) at the next edge.
- R5: After a split, the first advance whose `adv_pc` equals that split's meeting address sets `cur_pc` to the split's `br_fall_pc`. It also sets `act_mask` to (NOT predicate AND the mask before the split). The two paths therefore run one after the other, and the cost is the sum of their lengths.
- R6: The second advance to the same meeting address sets `cur_pc` to that address and restores `act_mask` to the mask held just before the split.
- R7: An advance whose `adv_pc` does not match the top pending meeting address, or that arrives with no pending split, sets `cur_pc` to `adv_pc` and leaves `act_mask` unchanged.
- R8: Splits nest up to `DEPTH` (default 4) levels. Each inner split divides only the lanes active at that moment, and pending splits unwind in last-in, first-out order.
- R9: A split that arrives with `DEPTH` splits pending sets `ovf_err`, which stays 1 until reset. `cur_pc`, `act_mask` and all pending entries are unchanged, and they unwind afterwards exactly as they would have without the dropped split.
- R10: When `br_valid` and `adv_valid` are both high in the same cycle, the branch is processed and the advance is ignored.
- R11: A uniform branch leaves nothing pending: a later advance to its meeting address behaves as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| br_valid | input | 1 | A conditional branch is issued this cycle |
| br_pred | input | LANES | Per-lane branch vote, 1 = go to target |
| br_taken_pc | input | PC_W | Branch target address |
| br_fall_pc | input | PC_W | Sequential successor of the branch |
| br_reconv_pc | input | PC_W | Address where both paths meet again |
| adv_valid | input | 1 | Warp stepped to a new address without branching |
| adv_pc | input | PC_W | Address reached by that step |
| cur_pc | output | PC_W | Address issued to all lanes |
| act_mask | output | LANES | Lanes enabled for the current address |
| ovf_err | output | 1 | Sticky flag: a split was dropped because the stack was full |

## Verification
A corrupted pending entry stays hidden until the warp reaches the matching meeting address. At that point it shows up on the very next edge, as a wrong second-path address, a wrong second-path mask or a wrong restored mask. The bench therefore unwinds every split it creates, including a stack filled to its limit, and compares `cur_pc` and `act_mask` after every single step. A wrong split calculation shows up one edge after the branch, as a mask holding lanes that were off or lanes that voted the other way. The stimulus includes predicates with bits set on inactive lanes to expose exactly that.

// File: rtl/simt_pkg.sv
// Package: shared event encoding for the warp reconvergence logic.
// Assumes: one event is chosen per cycle by the top module.
package simt_pkg;

    typedef enum logic [2:0] {
        EV_HOLD,      // nothing issued this cycle
        EV_UNIFORM,   // all active lanes agree
        EV_SPLIT,     // active lanes disagree, push pending path
        EV_OVERFLOW,  // disagreement with a full stack
        EV_SWITCH,    // first arrival at meeting point: start second path
        EV_RESTORE,   // second arrival: pop and restore mask
        EV_STEP       // plain sequential advance
    } simt_ev_e;

endpackage

// File: rtl/simt_branch_eval.sv
// Module: splits a per-lane vote into the two path masks under the current
// active mask and reports whether the active lanes disagree.
// Assumes: active mask is never zero while a branch is issued.
module simt_branch_eval #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] mask_i,
    input  logic [LANES-1:0] pred_i,
    output logic [LANES-1:0] take_m_o,
    output logic [LANES-1:0] skip_m_o,
    output logic             any_take_o,
    output logic             split_o
);

    // Purpose: restrict both votes to lanes that are currently enabled.
    always_comb begin
        take_m_o   = pred_i & mask_i;
        skip_m_o   = ~pred_i & mask_i;
        any_take_o = |take_m_o;
        split_o    = any_take_o && (|skip_m_o);
    end

endmodule

// File: rtl/simt_recon_stack.sv
// Module: LIFO of pending splits. Each entry holds a meeting address, the
// address and mask of the path still to run, the mask to restore, and a
// phase bit (0 = second path not started, 1 = second path running).
// Assumes: caller never pushes when full and never pops or flips when empty.
module simt_recon_stack #(
    parameter int LANES = 32,
    parameter int PC_W  = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flip,
    input  logic [PC_W-1:0]  push_rpc,
    input  logic [PC_W-1:0]  push_ppc,
    input  logic [LANES-1:0] push_pmask,
    input  logic [LANES-1:0] push_omask,
    output logic [PC_W-1:0]  top_rpc,
    output logic [PC_W-1:0]  top_ppc,
    output logic [LANES-1:0] top_pmask,
    output logic [LANES-1:0] top_omask,
    output logic             top_phase,
    output logic             empty,
    output logic             full
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] top_idx;
    logic [PC_W-1:0]  rpc_q   [DEPTH];
    logic [PC_W-1:0]  ppc_q   [DEPTH];
    logic [LANES-1:0] pmask_q [DEPTH];
    logic [LANES-1:0] omask_q [DEPTH];
    logic [DEPTH-1:0] phase_q;

    // Purpose: derive occupancy flags and the index of the top entry.
    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == CNT_W'(DEPTH));
        top_idx = IDX_W'(cnt - 1'b1);
    end

    // Purpose: expose the top entry's fields.
    always_comb begin
        top_rpc   = rpc_q[top_idx];
        top_ppc   = ppc_q[top_idx];
        top_pmask = pmask_q[top_idx];
        top_omask = omask_q[top_idx];
        top_phase = phase_q[top_idx];
    end

    // Purpose: track the number of pending splits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (push)
            cnt <= cnt + 1'b1;
        else if (pop)
            cnt <= cnt - 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Purpose: write one slot on push into it, mark its phase on flip.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rpc_q[g]   <= '0;
                ppc_q[g]   <= '0;
                pmask_q[g] <= '0;
                omask_q[g] <= '0;
                phase_q[g] <= 1'b0;
            end else if (push && (cnt == CNT_W'(g))) begin
                rpc_q[g]   <= push_rpc;
                ppc_q[g]   <= push_ppc;
                pmask_q[g] <= push_pmask;
                omask_q[g] <= push_omask;
                phase_q[g] <= 1'b0;
            end else if (flip && (top_idx == IDX_W'(g)) && !empty) begin
                phase_q[g] <= 1'b1;
            end
        end
    end

    // R9: the top module must never push into a full stack.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R6: pop and flip only act on an existing entry.
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || flip) |-> !empty);

    // R8: at most one stack operation per cycle.
    p_one_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push, pop, flip}));

    // R8: a push deepens the stack by exactly one.
    p_push_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/simt_warp_reconv.sv
// Module: program counter and active-lane mask of one warp, with serialized
// execution of divergent branch paths and reconvergence at a given address.
// Assumes: fetch reports each non-branch step on adv_*, branches on br_*;
// nested splits use distinct meeting addresses.
module simt_warp_reconv
    import simt_pkg::*;
#(
    parameter int              LANES    = 32,
    parameter int              PC_W     = 32,
    parameter int              DEPTH    = 4,
    parameter logic [PC_W-1:0] RESET_PC = 'h100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_pred,
    input  logic [PC_W-1:0]  br_taken_pc,
    input  logic [PC_W-1:0]  br_fall_pc,
    input  logic [PC_W-1:0]  br_reconv_pc,
    input  logic             adv_valid,
    input  logic [PC_W-1:0]  adv_pc,
    output logic [PC_W-1:0]  cur_pc,
    output logic [LANES-1:0] act_mask,
    output logic             ovf_err
);

    logic [LANES-1:0] take_m, skip_m;
    logic             any_take, split;
    logic [PC_W-1:0]  top_rpc, top_ppc;
    logic [LANES-1:0] top_pmask, top_omask;
    logic             top_phase, st_empty, st_full;
    logic             hit;
    simt_ev_e         ev;

    simt_branch_eval #(.LANES(LANES)) u_eval (
        .mask_i     (act_mask),
        .pred_i     (br_pred),
        .take_m_o   (take_m),
        .skip_m_o   (skip_m),
        .any_take_o (any_take),
        .split_o    (split)
    );

    simt_recon_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (ev == EV_SPLIT),
        .pop        (ev == EV_RESTORE),
        .flip       (ev == EV_SWITCH),
        .push_rpc   (br_reconv_pc),
        .push_ppc   (br_fall_pc),
        .push_pmask (skip_m),
        .push_omask (act_mask),
        .top_rpc    (top_rpc),
        .top_ppc    (top_ppc),
        .top_pmask  (top_pmask),
        .top_omask  (top_omask),
        .top_phase  (top_phase),
        .empty      (st_empty),
        .full       (st_full)
    );

    // Purpose: choose this cycle's event; a branch outranks an advance.
    always_comb begin
        hit = !st_empty && (adv_pc == top_rpc);
        if (br_valid)
            ev = split ? (st_full ? EV_OVERFLOW : EV_SPLIT) : EV_UNIFORM;
        else if (adv_valid)
            ev = hit ? (top_phase ? EV_RESTORE : EV_SWITCH) : EV_STEP;
        else
            ev = EV_HOLD;
    end

    // Purpose: update the issued address, lane mask and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pc   <= RESET_PC;
            act_mask <= '1;
            ovf_err  <= 1'b0;
        end else begin
            unique case (ev)
                EV_UNIFORM:  cur_pc <= any_take ? br_taken_pc : br_fall_pc;
                EV_SPLIT: begin
                    cur_pc   <= br_taken_pc;
                    act_mask <= take_m;
                end
                EV_OVERFLOW: ovf_err <= 1'b1;
                EV_SWITCH: begin
                    cur_pc   <= top_ppc;
                    act_mask <= top_pmask;
                end
                EV_RESTORE: begin
                    cur_pc   <= adv_pc;
                    act_mask <= top_omask;
                end
                EV_STEP:     cur_pc <= adv_pc;
                default:     ;
            endcase
        end
    end

    // R1: an enabled warp always has at least one lane.
    p_mask_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        act_mask != '0);

    // R2: a uniform branch keeps the mask.
    p_uniform_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !split) |=> (act_mask == $past(act_mask)));

    // R4: a split narrows the mask to a proper subset of the old one.
    p_split_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SPLIT) |=> (((act_mask & ~$past(act_mask)) == '0)
                              && (act_mask != $past(act_mask))));

    // R6: restoring never drops a lane that was running.
    p_restore_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RESTORE) |=> ((~act_mask & $past(act_mask)) == '0));

    // R9: a dropped split freezes address and mask, and the flag sticks.
    p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && split && st_full) |=>
            ($stable(cur_pc) && $stable(act_mask) && ovf_err));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

endmodule

// File: tb/sim_simt_warp_reconv.sv
module sim_simt_warp_reconv;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 32;
    localparam int PC_W  = 32;
    localparam int NVEC  = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             br_valid = 1'b0;
    logic [LANES-1:0] br_pred = '0;
    logic [PC_W-1:0]  br_taken_pc = '0, br_fall_pc = '0, br_reconv_pc = '0;
    logic             adv_valid = 1'b0;
    logic [PC_W-1:0]  adv_pc = '0;
    logic [PC_W-1:0]  cur_pc;
    logic [LANES-1:0] act_mask;
    logic             ovf_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simt_warp_reconv u0 (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_pred(br_pred), .br_taken_pc(br_taken_pc),
        .br_fall_pc(br_fall_pc), .br_reconv_pc(br_reconv_pc),
        .adv_valid(adv_valid), .adv_pc(adv_pc),
        .cur_pc(cur_pc), .act_mask(act_mask), .ovf_err(ovf_err)
    );

    // Vector table: kind 1 = branch (A taken, B fall, C meet), 0 = advance to A.
    localparam bit          T_BR   [NVEC] = '{0, 1, 1, 0, 1, 0, 1, 1, 0, 0, 0, 0};
    localparam logic [31:0] T_PRED [NVEC] = '{
        32'h0, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0000FFFF, 32'h0,
        32'hFFFF0000, 32'hAAAA00FF, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam logic [31:0] T_A [NVEC] = '{
        32'h104, 32'h200, 32'h400, 32'h500, 32'h600, 32'h604,
        32'h900, 32'hA00, 32'hC00, 32'hC00, 32'h800, 32'h800};
    localparam logic [31:0] T_B [NVEC] = '{
        32'h0, 32'h108, 32'h204, 32'h0, 32'h700, 32'h0,
        32'h608, 32'hB00, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam logic [31:0] T_C [NVEC] = '{
        32'h0, 32'h300, 32'h500, 32'h0, 32'h800, 32'h0,
        32'h9F0, 32'hC00, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam logic [31:0] T_EPC [NVEC] = '{
        32'h104, 32'h200, 32'h204, 32'h500, 32'h600, 32'h604,
        32'h608, 32'hA00, 32'hB00, 32'hC00, 32'h700, 32'h800};
    localparam logic [31:0] T_EMASK [NVEC] = '{
        32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
        32'h0000FFFF, 32'h0000FFFF, 32'h0000FFFF, 32'h000000FF,
        32'h0000FF00, 32'h0000FFFF, 32'hFFFF0000, 32'hFFFFFFFF};
    // Requirement per row: R7 R2 R2 R11 R4 R7 R3 R8 R5 R6 R5 R6
    localparam int T_REQ [NVEC] = '{7, 2, 2, 11, 4, 7, 3, 8, 5, 6, 5, 6};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next fall.
    task automatic do_branch(input logic [31:0] p, input logic [31:0] t,
                             input logic [31:0] f, input logic [31:0] m);
        br_valid = 1'b1; br_pred = p; br_taken_pc = t; br_fall_pc = f; br_reconv_pc = m;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic do_adv(input logic [31:0] a);
        adv_valid = 1'b1; adv_pc = a;
        @(negedge clk);
        adv_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] orig [4];
        logic [31:0] tk   [4];
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1 pc", cur_pc, 32'h100);
        check("R1 mask", act_mask, 32'hFFFFFFFF);
        check("R1 ovf", {31'b0, ovf_err}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (T_BR[i]) do_branch(T_PRED[i], T_A[i], T_B[i], T_C[i]);
            else         do_adv(T_A[i]);
            check($sformatf("R%0d row %0d pc", T_REQ[i], i), cur_pc, T_EPC[i]);
            check($sformatf("R%0d row %0d mask", T_REQ[i], i), act_mask, T_EMASK[i]);
        end

        // R10: branch and advance together; branch wins.
        br_valid = 1'b1; br_pred = 32'hFFFFFFFF; br_taken_pc = 32'hD00;
        br_fall_pc = 32'hD04; br_reconv_pc = 32'hD80;
        adv_valid = 1'b1; adv_pc = 32'hE00;
        @(negedge clk);
        br_valid = 1'b0; adv_valid = 1'b0;
        check("R10 pc", cur_pc, 32'hD00);
        check("R10 mask", act_mask, 32'hFFFFFFFF);

        // R8/R9: fill the stack with four nested splits, then overflow.
        orig = '{32'hFFFFFFFF, 32'h0000FFFF, 32'h000000FF, 32'h0000000F};
        tk   = '{32'h0000FFFF, 32'h000000FF, 32'h0000000F, 32'h00000003};
        for (int k = 0; k < 4; k++) begin
            do_branch(tk[k] | 32'hF0000000 & ~orig[k], 32'h2000 + 32'(k) * 16,
                      32'h3000 + 32'(k) * 16, 32'h4000 + 32'(k) * 16);
            check("R8 nest pc", cur_pc, 32'h2000 + 32'(k) * 16);
            check("R8 nest mask", act_mask, tk[k]);
        end
        check("R9 ovf before", {31'b0, ovf_err}, 32'h0);
        do_branch(32'h00000001, 32'h5000, 32'h5004, 32'h5008);
        check("R9 ovf set", {31'b0, ovf_err}, 32'h1);
        check("R9 pc hold", cur_pc, 32'h2030);
        check("R9 mask hold", act_mask, 32'h00000003);

        // R8/R9: unwind in LIFO order; entries intact, flag sticky.
        for (int k = 3; k >= 0; k--) begin
            do_adv(32'h4000 + 32'(k) * 16);
            check("R5 unwind pc", cur_pc, 32'h3000 + 32'(k) * 16);
            check("R5 unwind mask", act_mask, orig[k] & ~tk[k]);
            do_adv(32'h4000 + 32'(k) * 16);
            check("R6 unwind pc", cur_pc, 32'h4000 + 32'(k) * 16);
            check("R6 unwind mask", act_mask, orig[k]);
        end
        check("R9 ovf sticky", {31'b0, ovf_err}, 32'h1);

        // R7: stack empty now, advance is plain.
        do_adv(32'h4000);
        check("R7 empty pc", cur_pc, 32'h4000);
        check("R7 empty mask", act_mask, 32'hFFFFFFFF);

        // R1: reset clears flag and returns to start.
        do_branch(32'h0000FFFF, 32'h6000, 32'h6004, 32'h6008);
        do_reset();
        check("R1 re pc", cur_pc, 32'h100);
        check("R1 re mask", act_mask, 32'hFFFFFFFF);
        check("R1 re ovf", {31'b0, ovf_err}, 32'h0);
        // R7: the split before reset left nothing pending.
        do_adv(32'h6008);
        check("R7 post-reset mask", act_mask, 32'hFFFFFFFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule